// File: doc/BRIEF.md
# MSI Two-Level Indicator Bit Setter

This block receives message-signalled interrupt writes from one PCI function and turns each of them into set bits in host memory. A vector number taken from the written word selects one bit in a per-function indicator array. A fixed bit in a shared summary array is then set as well. The block raises an adapter interrupt toward the host, tagged with the configured interrupt subclass, only when that summary bit's byte was entirely clear beforehand. While the byte is non-zero, the host is already due to scan the arrays, so further messages only add indicator bits.

Software supplies the configuration: the base addresses and starting bit offsets of both arrays, the subclass, and a flag saying the function is enabled. Bits are numbered most-significant first inside each byte. Every update is a byte read followed by a byte write of the OR-ed value, issued over a simple request/acknowledge memory port that can flag an error. A failed access produces an error-event pulse. Reads of the message window never touch memory and always return all ones.

Top module: `msi_ind_setter`

## Requirements
- R1: The vector is the low VEC_W bits of `msg_data`; the upper bits of the written word have no effect on any address, mask or event.
- R2: A message write accepted while `cfg_enabled` is low produces no memory access, no interrupt and no error event.
- R3: The indicator byte address is `cfg_ind_base + ((cfg_ind_off + vector) >> 3)`, computed modulo 2^ADDR_W.
- R4: The indicator bit mask is `8'h80 >> ((cfg_ind_off + vector) & 7)`, so bit position 0 is the byte's MSB. The byte written back is the previously read value OR-ed with the mask, and every other bit of memory is left as it was.
- R5: The summary byte is `cfg_sum_base + (cfg_sum_off >> 3)` with mask `8'h80 >> (cfg_sum_off & 7)`, independent of the vector, and is updated by OR in the same way as the indicator byte.
- R6: Each enabled message performs exactly four accesses in this order: indicator read, indicator write, summary read, summary write. The address and direction stay stable until acknowledged, and `msg_ready` is low from acceptance until the last access completes.
- R7: `irq_valid` pulses for one cycle, with `irq_isc` equal to the subclass sampled at acceptance, only if the summary read returned 8'h00 and both summary accesses completed without error.
- R8: An access acknowledged with `mem_err` causes a one-cycle `err_event` pulse. A failed indicator read skips the indicator write but the summary update still runs. A failed summary access ends the message with no interrupt.
- R9: A message read is accepted when `msg_ready` is high. It produces a one-cycle `rd_valid` with `rd_data` = 32'hFFFFFFFF on the next cycle and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enabled | input | 1 | Function is in the enabled state |
| cfg_ind_base | input | ADDR_W | Indicator array byte base address |
| cfg_ind_off | input | OFF_W | Indicator array starting bit offset |
| cfg_sum_base | input | ADDR_W | Summary array byte base address |
| cfg_sum_off | input | OFF_W | Summary bit offset |
| cfg_isc | input | ISC_W | Interrupt subclass |
| msg_valid | input | 1 | Message access present |
| msg_write | input | 1 | 1 = write, 0 = read |
| msg_data | input | DATA_W | Written message data |
| msg_ready | output | 1 | Block can accept a message |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete (may arrive in the request cycle) |
| mem_err | input | 1 | Access failed, qualified by acknowledge |
| irq_valid | output | 1 | Adapter interrupt pulse |
| irq_isc | output | ISC_W | Subclass of the interrupt |
| err_event | output | 1 | Routing error event pulse |

## Verification
The bench builds the block with ADDR_W=8, OFF_W=5, VEC_W=4 and ISC_W=3. This makes the whole 16 x 16 space of indicator offset and vector reachable, covering every MSB-first bit position and every carry into the byte index. All 32 summary offsets are also swept against a 256-byte memory model that can fail a chosen address. At these widths the OR preservation, the zero-summary interrupt rule and both error paths can each be checked against a memory image computed arithmetically in the bench.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_IND_RD = 3'd1,
      ST_IND_WR = 3'd2,
      ST_SUM_RD = 3'd3,
      ST_SUM_WR = 3'd4
   } seq_state_t;

endpackage

// File: rtl/msi_bit_locate.sv
module msi_bit_locate #(
   parameter int ADDR_W = 64,
   parameter int POS_W  = 17
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [POS_W-1:0]  pos,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [7:0]        bit_mask
);

   localparam int IDX_W = POS_W - 3;

   initial begin
      assert (POS_W >= 4) else $error("msi_bit_locate: POS_W must be at least 4");
   end

   logic [ADDR_W-1:0] idx_ext;

   generate
      if (IDX_W >= ADDR_W) begin : g_trunc
         assign idx_ext = pos[ADDR_W+2:3];
      end else begin : g_zext
         assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, pos[POS_W-1:3]};
      end
   endgenerate

   assign byte_addr = base + idx_ext;
   assign bit_mask  = 8'h80 >> pos[2:0];

endmodule

// File: rtl/msi_rmw_seq.sv
module msi_rmw_seq
   import msi_ind_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] ind_addr,
   input  logic [7:0]        ind_mask,
   input  logic [ADDR_W-1:0] sum_addr,
   input  logic [7:0]        sum_mask,
   output logic              busy,
   output logic              irq_pulse,
   output logic              err_pulse,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err
);

   seq_state_t state;
   logic [7:0] old_q;
   logic       on_ind;

   assign on_ind    = (state == ST_IND_RD) || (state == ST_IND_WR);
   assign busy      = (state != ST_IDLE);
   assign mem_req   = busy;
   assign mem_wr    = (state == ST_IND_WR) || (state == ST_SUM_WR);
   assign mem_addr  = on_ind ? ind_addr : sum_addr;
   assign mem_wdata = old_q | (on_ind ? ind_mask : sum_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         old_q     <= 8'h00;
         irq_pulse <= 1'b0;
         err_pulse <= 1'b0;
      end else begin
         irq_pulse <= 1'b0;
         err_pulse <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) state <= ST_IND_RD;
            end
            ST_IND_RD: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     err_pulse <= 1'b1;
                     state     <= ST_SUM_RD;
                  end else begin
                     old_q <= mem_rdata;
                     state <= ST_IND_WR;
                  end
               end
            end
            ST_IND_WR: begin
               if (mem_ack) begin
                  err_pulse <= mem_err;
                  state     <= ST_SUM_RD;
               end
            end
            ST_SUM_RD: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     err_pulse <= 1'b1;
                     state     <= ST_IDLE;
                  end else begin
                     old_q <= mem_rdata;
                     state <= ST_SUM_WR;
                  end
               end
            end
            ST_SUM_WR: begin
               if (mem_ack) begin
                  if (mem_err) err_pulse <= 1'b1;
                  else         irq_pulse <= (old_q == 8'h00);
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wr)) else $error("AST_REQ_HOLD"); // R6

   AST_WR_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> mem_addr == $past(mem_addr)) else $error("AST_WR_SAME_BYTE"); // R6

   AST_IRQ_AFTER_SUM_WR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(mem_ack && mem_wr && !mem_err)) else $error("AST_IRQ_AFTER_SUM_WR"); // R7

   AST_ERR_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(mem_ack && mem_err)) else $error("AST_ERR_FROM_PORT"); // R8

endmodule

// File: rtl/msi_ind_setter.sv
module msi_ind_setter #(
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 16,
   parameter int VEC_W  = 11,
   parameter int ISC_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enabled,
   input  logic [ADDR_W-1:0] cfg_ind_base,
   input  logic [OFF_W-1:0]  cfg_ind_off,
   input  logic [ADDR_W-1:0] cfg_sum_base,
   input  logic [OFF_W-1:0]  cfg_sum_off,
   input  logic [ISC_W-1:0]  cfg_isc,
   input  logic              msg_valid,
   input  logic              msg_write,
   input  logic [DATA_W-1:0] msg_data,
   output logic              msg_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              irq_valid,
   output logic [ISC_W-1:0]  irq_isc,
   output logic              err_event
);

   localparam int POS_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

   initial begin
      assert (VEC_W >= 1 && VEC_W < DATA_W) else $error("msi_ind_setter: VEC_W out of range");
      assert (OFF_W >= 3) else $error("msi_ind_setter: OFF_W must be at least 3");
      assert (ADDR_W >= 4) else $error("msi_ind_setter: ADDR_W must be at least 4");
      assert (ISC_W >= 1) else $error("msi_ind_setter: ISC_W must be at least 1");
   end

   logic              busy;
   logic              accept;
   logic              start;
   logic [VEC_W-1:0]  vec_q;
   logic [ISC_W-1:0]  isc_q;
   logic [POS_W-1:0]  ind_pos;
   logic [POS_W-1:0]  sum_pos;
   logic [ADDR_W-1:0] ind_addr;
   logic [ADDR_W-1:0] sum_addr;
   logic [7:0]        ind_mask;
   logic [7:0]        sum_mask;
   logic              unused_msg_hi;

   assign unused_msg_hi = ^msg_data[DATA_W-1:VEC_W];

   assign msg_ready = !busy;
   assign accept    = msg_valid && msg_ready;
   assign start     = accept && msg_write && cfg_enabled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q    <= '0;
         isc_q    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= accept && !msg_write;
         if (start) begin
            vec_q <= msg_data[VEC_W-1:0];
            isc_q <= cfg_isc;
         end
      end
   end

   assign rd_data = rd_valid ? {DATA_W{1'b1}} : '0;
   assign irq_isc = isc_q;

   assign ind_pos = POS_W'(cfg_ind_off) + POS_W'(vec_q);
   assign sum_pos = POS_W'(cfg_sum_off);

   msi_bit_locate #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_ind_loc (
      .base      (cfg_ind_base),
      .pos       (ind_pos),
      .byte_addr (ind_addr),
      .bit_mask  (ind_mask)
   );

   msi_bit_locate #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_sum_loc (
      .base      (cfg_sum_base),
      .pos       (sum_pos),
      .byte_addr (sum_addr),
      .bit_mask  (sum_mask)
   );

   msi_rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ind_addr  (ind_addr),
      .ind_mask  (ind_mask),
      .sum_addr  (sum_addr),
      .sum_mask  (sum_mask),
      .busy      (busy),
      .irq_pulse (irq_valid),
      .err_pulse (err_event),
      .mem_req   (mem_req),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err)
   );

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !msg_ready) else $error("AST_BUSY_NOT_READY"); // R6

   AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_write && msg_ready && !cfg_enabled |=> !mem_req) else $error("AST_DISABLED_NO_START"); // R2

   AST_READ_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(mem_req)) else $error("AST_READ_NO_ACCESS"); // R9

endmodule

// File: tb/msi_ind_setter_bench.sv
module msi_ind_setter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int OW = 5;
   localparam int VW = 4;
   localparam int IW = 3;
   localparam int DW = 32;
   localparam logic [AW-1:0] IND_BASE = 8'h10;
   localparam logic [AW-1:0] SUM_BASE = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enabled = 1'b1;
   logic [AW-1:0] cfg_ind_base = IND_BASE;
   logic [OW-1:0] cfg_ind_off = '0;
   logic [AW-1:0] cfg_sum_base = SUM_BASE;
   logic [OW-1:0] cfg_sum_off = '0;
   logic [IW-1:0] cfg_isc = '0;
   logic          msg_valid = 1'b0;
   logic          msg_write = 1'b0;
   logic [DW-1:0] msg_data = '0;
   logic          msg_ready;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          mem_req;
   logic          mem_wr;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata;
   logic          mem_ack;
   logic          mem_err;
   logic          irq_valid;
   logic [IW-1:0] irq_isc;
   logic          err_event;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_ind_setter #(.ADDR_W(AW), .OFF_W(OW), .VEC_W(VW), .ISC_W(IW), .DATA_W(DW)) u_msi_ind_setter (
      .clk(clk), .rst_n(rst_n), .cfg_enabled(cfg_enabled),
      .cfg_ind_base(cfg_ind_base), .cfg_ind_off(cfg_ind_off),
      .cfg_sum_base(cfg_sum_base), .cfg_sum_off(cfg_sum_off), .cfg_isc(cfg_isc),
      .msg_valid(msg_valid), .msg_write(msg_write), .msg_data(msg_data),
      .msg_ready(msg_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .irq_valid(irq_valid), .irq_isc(irq_isc), .err_event(err_event)
   );

   // memory model: zero-wait acknowledge, one address can be made to fail
   logic [7:0]    mem [0:255];
   logic          mem_clr = 1'b0;
   logic          pre_en = 1'b0;
   logic [AW-1:0] pre_addr = '0;
   logic [7:0]    pre_val = '0;
   logic          fail_en = 1'b0;
   logic [AW-1:0] fail_addr = '0;
   logic [AW-1:0] log_addr [0:2047];
   logic          log_wr [0:2047];
   int            log_n = 0;
   int            irq_cnt = 0;
   int            err_cnt = 0;
   int            rd_cnt = 0;
   logic [IW-1:0] last_isc = '0;
   logic [DW-1:0] last_rd = '0;

   assign mem_ack   = mem_req;
   assign mem_err   = mem_req && fail_en && (mem_addr == fail_addr);
   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (mem_clr) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      end else if (pre_en) begin
         mem[pre_addr] <= pre_val;
      end else if (mem_req && mem_wr && !mem_err) begin
         mem[mem_addr] <= mem_wdata;
      end
      if (mem_req && log_n < 2048) begin
         log_addr[log_n] <= mem_addr;
         log_wr[log_n]   <= mem_wr;
         log_n           <= log_n + 1;
      end
      if (irq_valid) begin
         irq_cnt  <= irq_cnt + 1;
         last_isc <= irq_isc;
      end
      if (err_event) err_cnt <= err_cnt + 1;
      if (rd_valid) begin
         rd_cnt  <= rd_cnt + 1;
         last_rd <= rd_data;
      end
   end

   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int mem_ones();
      int s = 0;
      for (int i = 0; i < 256; i++) s += $countones(mem[i]);
      return s;
   endfunction

   task automatic clear_mem();
      @(negedge clk); mem_clr = 1'b1;
      @(negedge clk); mem_clr = 1'b0;
   endtask

   task automatic preset(input logic [AW-1:0] a, input logic [7:0] v);
      @(negedge clk); pre_en = 1'b1; pre_addr = a; pre_val = v;
      @(negedge clk); pre_en = 1'b0;
   endtask

   task automatic send(input bit wr, input logic [DW-1:0] d);
      @(negedge clk);
      while (!msg_ready) @(negedge clk);
      msg_valid = 1'b1; msg_write = wr; msg_data = d;
      @(negedge clk);
      msg_valid = 1'b0; msg_write = 1'b0;
      repeat (7) @(negedge clk);
   endtask

   function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int pos);
      return b + AW'(pos >> 3);
   endfunction

   function automatic logic [7:0] exp_mask(input int pos);
      return 8'h80 >> (pos % 8);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R6 actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int base_log, base_irq, base_err, base_rd, pos;
      logic [AW-1:0] ia, sa;
      logic [7:0] im, sm;

      repeat (4) @(negedge clk);
      // reset state
      chk(msg_ready === 1'b1, "R6 reset ready", 64'(msg_ready), 1);
      chk(mem_req === 1'b0 && irq_valid === 1'b0 && err_event === 1'b0 && rd_valid === 1'b0,
          "R6 reset outputs idle", {mem_req, irq_valid, err_event, rd_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3 R4 R6 R7: sweep indicator offset x vector
      cfg_sum_off = 5'd13;
      for (int io = 0; io < 16; io++) begin
         for (int v = 0; v < 16; v++) begin
            clear_mem();
            cfg_ind_off = OW'(io);
            cfg_isc = IW'(io + v);
            base_log = log_n; base_irq = irq_cnt;
            send(1'b1, {28'(io * 37 + v * 11 + 5), 4'(v)});
            pos = io + v;
            ia = exp_addr(IND_BASE, pos); im = exp_mask(pos);
            sa = exp_addr(SUM_BASE, 13); sm = exp_mask(13);
            chk(mem[ia] == im, "R3 R4 R1 indicator byte", mem[ia], im);
            chk(mem[sa] == sm, "R5 summary byte", mem[sa], sm);
            chk(mem_ones() == 2, "R4 no other bits touched", mem_ones(), 2);
            chk(log_n - base_log == 4 && log_addr[base_log] == ia && !log_wr[base_log] &&
                log_addr[base_log+1] == ia && log_wr[base_log+1] &&
                log_addr[base_log+2] == sa && !log_wr[base_log+2] &&
                log_addr[base_log+3] == sa && log_wr[base_log+3],
                "R6 access order", log_n - base_log, 4);
            chk(irq_cnt - base_irq == 1 && last_isc == IW'(io + v), "R7 irq on clear summary",
                {32'(irq_cnt - base_irq), 32'(last_isc)}, {32'd1, 32'(IW'(io + v))});
         end
      end

      // R5: sweep summary offset
      cfg_ind_off = '0;
      for (int so = 0; so < 32; so++) begin
         clear_mem();
         cfg_sum_off = OW'(so);
         send(1'b1, 32'h0000_0003);
         sa = exp_addr(SUM_BASE, so); sm = exp_mask(so);
         chk(mem[sa] == sm, "R5 summary offset sweep", mem[sa], sm);
         chk(mem[IND_BASE] == 8'h10, "R5 summary independent of vector", mem[IND_BASE], 8'h10);
      end

      // R7: summary byte already non-zero, no interrupt; R4: OR keeps old bits
      clear_mem();
      cfg_sum_off = 5'd2; cfg_ind_off = 5'd0;
      preset(SUM_BASE, 8'h01);
      preset(IND_BASE + 8'd1, 8'h0F);
      base_irq = irq_cnt;
      send(1'b1, 32'h0000_0008);
      chk(irq_cnt == base_irq, "R7 no irq when summary byte non-zero", irq_cnt - base_irq, 0);
      chk(mem[SUM_BASE] == 8'h21, "R4 R5 summary OR keeps old", mem[SUM_BASE], 8'h21);
      chk(mem[IND_BASE + 8'd1] == 8'h8F, "R4 indicator OR keeps old", mem[IND_BASE + 8'd1], 8'h8F);
      // summary bit itself already set, same byte
      base_irq = irq_cnt;
      send(1'b1, 32'h0000_0001);
      chk(irq_cnt == base_irq, "R7 repeated message no irq", irq_cnt - base_irq, 0);
      chk(mem[IND_BASE] == 8'h40, "R3 second vector set", mem[IND_BASE], 8'h40);

      // R2: disabled function ignores writes
      clear_mem();
      cfg_enabled = 1'b0;
      base_log = log_n; base_irq = irq_cnt; base_err = err_cnt;
      send(1'b1, 32'h0000_0005);
      chk(log_n == base_log, "R2 no access when disabled", log_n - base_log, 0);
      chk(irq_cnt == base_irq && err_cnt == base_err, "R2 no events when disabled",
          irq_cnt - base_irq + err_cnt - base_err, 0);
      chk(mem_ones() == 0, "R2 memory unchanged", mem_ones(), 0);
      cfg_enabled = 1'b1;

      // R9: reads return all ones without memory traffic
      base_log = log_n; base_rd = rd_cnt;
      send(1'b0, 32'h0000_0002);
      chk(rd_cnt - base_rd == 1, "R9 one read response", rd_cnt - base_rd, 1);
      chk(last_rd == 32'hFFFF_FFFF, "R9 read value", last_rd, 32'hFFFF_FFFF);
      chk(log_n == base_log, "R9 no access on read", log_n - base_log, 0);

      // R8: failing indicator byte, summary still updated and interrupt raised
      clear_mem();
      cfg_ind_off = 5'd0; cfg_sum_off = 5'd0;
      fail_en = 1'b1; fail_addr = IND_BASE;
      base_log = log_n; base_irq = irq_cnt; base_err = err_cnt;
      send(1'b1, 32'h0000_0001);
      chk(err_cnt - base_err == 1, "R8 indicator error event", err_cnt - base_err, 1);
      chk(log_n - base_log == 3, "R8 indicator write skipped", log_n - base_log, 3);
      chk(mem[SUM_BASE] == 8'h80, "R8 summary still set", mem[SUM_BASE], 8'h80);
      chk(irq_cnt - base_irq == 1, "R8 irq after indicator error", irq_cnt - base_irq, 1);

      // R8: failing summary byte, no interrupt
      clear_mem();
      fail_addr = SUM_BASE;
      base_irq = irq_cnt; base_err = err_cnt; base_log = log_n;
      send(1'b1, 32'h0000_0009);
      chk(err_cnt - base_err == 1, "R8 summary error event", err_cnt - base_err, 1);
      chk(irq_cnt == base_irq, "R8 no irq after summary error", irq_cnt - base_irq, 0);
      chk(mem[IND_BASE + 8'd1] == 8'h40, "R8 indicator still set", mem[IND_BASE + 8'd1], 8'h40);
      chk(log_n - base_log == 3, "R8 summary write skipped", log_n - base_log, 3);
      fail_en = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule